// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block tracks which lanes of a 32-lane SIMD thread are allowed to commit results while the thread walks through nested if/else regions. Every lane steps through both sides of a branch; the active mask decides which lanes commit. When a branch diverges, the current mask is saved on a stack and narrowed by the per-lane predicate. At the else point, the lanes that were active before the branch but did not take it become active. At reconvergence the saved mask is restored.

A sequencer drives one of three command strobes with the per-lane predicate. It reads the mask and a flag that says no lane is active, so it can skip a path whose mask is empty. Pushing onto a full stack and popping or flipping on an empty stack are refused and reported by one-cycle error pulses. The stack depth is a parameter. Each entry holds a full lane mask.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset, mask_o is all ones, all_off_o, ovf_o and unf_o are 0, and the stack is empty, so a first pop raises unf_o.
- R2: A push with free room saves the current mask on the stack. One cycle later mask_o equals the old mask ANDed with pred_i.
- R3: A push when DEPTH entries are held raises ovf_o for one cycle and leaves the mask and the stack unchanged.
- R4: A flip (else) with a non-empty stack sets the mask to the saved top entry ANDed with the inverse of the current mask. This equals the saved mask ANDed with the inverted branch predicate. The stack is unchanged.
- R5: A pop with a non-empty stack restores the top saved mask and removes that entry.
- R6: A pop or a flip on an empty stack raises unf_o for one cycle and leaves the mask unchanged.
- R7: all_off_o is 1 exactly when mask_o is all zeros.
- R8: When more than one strobe is high in a cycle, push wins over flip and flip wins over pop. Only the winner acts.
- R9: In a cycle with no strobe, the mask and the stack hold, and ovf_o and unf_o are 0 the next cycle.
- R10: Nested pushes are undone in last-in first-out order. Each pop restores the mask that was current before the matching push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Divergent branch: save the mask and narrow it by pred_i |
| flip_i | input | 1 | Else point: activate the lanes of the saved mask that were not taken |
| pop_i | input | 1 | Reconvergence: restore the saved mask |
| pred_i | input | LANES | Per-lane branch predicate, sampled on push |
| mask_o | output | LANES | Current active-lane mask |
| all_off_o | output | 1 | No lane is active |
| ovf_o | output | 1 | One-cycle pulse: push refused, stack full |
| unf_o | output | 1 | One-cycle pulse: pop or flip refused, stack empty |

## Verification
The assertions check the per-cycle relations at the ports on every cycle:
- an accepted push yields the old mask ANDed with the predicate;
- a flip yields a mask disjoint from the taken mask;
- idle cycles hold state;
- error pulses leave the mask untouched;
- overflow and underflow never coincide.

Only the bench's scenarios can show:
- nested last-in first-out restoration across several levels;
- the exact depth at which overflow begins;
- underflow right after reset;
- the strobe priority ordering.

These depend on history deeper than a single cycle.

// File: rtl/simt_mask_pkg.sv
package simt_mask_pkg;
    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_PUSH = 2'd1,
        CMD_FLIP = 2'd2,
        CMD_POP  = 2'd3
    } mask_cmd_e;
endpackage

// File: rtl/mask_cmd_decode.sv
module mask_cmd_decode
    import simt_mask_pkg::*;
(
    input  logic      push_i,
    input  logic      flip_i,
    input  logic      pop_i,
    output mask_cmd_e cmd_o
);
    // fixed priority: push, then flip, then pop
    always_comb begin
        if (push_i)      cmd_o = CMD_PUSH;
        else if (flip_i) cmd_o = CMD_FLIP;
        else if (pop_i)  cmd_o = CMD_POP;
        else             cmd_o = CMD_NONE;
    end
endmodule

// File: rtl/mask_stack_store.sv
module mask_stack_store #(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [LANES-1:0] wr_data,
    input  logic [IW-1:0]    rd_idx,
    output logic [LANES-1:0] rd_data
);
    logic [LANES-1:0] entry_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[g] <= '0;
            else if (wr_en && (wr_idx == IW'(g)))
                entry_q[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < DEPTH; k++)
            if (rd_idx == IW'(k)) rd_data = entry_q[k];
    end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack
    import simt_mask_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             flip_i,
    input  logic             pop_i,
    input  logic [LANES-1:0] pred_i,
    output logic [LANES-1:0] mask_o,
    output logic             all_off_o,
    output logic             ovf_o,
    output logic             unf_o
);
    localparam int SW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic [SW-1:0]    sp;
        logic             ovf;
        logic             unf;
    } state_t;

    state_t           st_d, st_q;
    mask_cmd_e        cmd;
    logic             wr_en;
    logic [IW-1:0]    wr_idx;
    logic [IW-1:0]    rd_idx;
    logic [LANES-1:0] top_mask;

    mask_cmd_decode u_dec (
        .push_i (push_i),
        .flip_i (flip_i),
        .pop_i  (pop_i),
        .cmd_o  (cmd)
    );

    mask_stack_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (st_q.mask),
        .rd_idx  (rd_idx),
        .rd_data (top_mask)
    );

    assign wr_idx = IW'(st_q.sp);
    assign rd_idx = IW'(st_q.sp - SW'(1));

    always_comb begin
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        wr_en    = 1'b0;
        unique case (cmd)
            CMD_PUSH: begin
                if (st_q.sp == SW'(DEPTH)) begin
                    st_d.ovf = 1'b1;
                end else begin
                    wr_en     = 1'b1;
                    st_d.sp   = st_q.sp + SW'(1);
                    st_d.mask = st_q.mask & pred_i;
                end
            end
            CMD_FLIP: begin
                if (st_q.sp == '0) st_d.unf = 1'b1;
                else               st_d.mask = top_mask & ~st_q.mask;
            end
            CMD_POP: begin
                if (st_q.sp == '0) begin
                    st_d.unf = 1'b1;
                end else begin
                    st_d.mask = top_mask;
                    st_d.sp   = st_q.sp - SW'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask <= '1;
            st_q.sp   <= '0;
            st_q.ovf  <= 1'b0;
            st_q.unf  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o    = st_q.mask;
    assign all_off_o = (st_q.mask == '0);
    assign ovf_o     = st_q.ovf;
    assign unf_o     = st_q.unf;
endmodule

// File: rtl/mask_stack_chk.sv
module mask_stack_chk #(
    parameter int LANES = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic             flip_i,
    input logic             pop_i,
    input logic [LANES-1:0] pred_i,
    input logic [LANES-1:0] mask_o,
    input logic             all_off_o,
    input logic             ovf_o,
    input logic             unf_o
);
    assert_push_narrows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (ovf_o || (mask_o == $past(mask_o & pred_i))));

    assert_ovf_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (mask_o == $past(mask_o)));

    assert_flip_disjoint_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flip_i && !push_i) |=> (unf_o || ((mask_o & $past(mask_o)) == '0)));

    assert_unf_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> (mask_o == $past(mask_o)));

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !flip_i && !pop_i) |=> ($stable(mask_o) && !ovf_o && !unf_o));

    assert_err_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));

    assert_alloff_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        all_off_o |-> ($countones(mask_o) == 0));
endmodule

bind simt_mask_stack mask_stack_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_i    (push_i),
    .flip_i    (flip_i),
    .pop_i     (pop_i),
    .pred_i    (pred_i),
    .mask_o    (mask_o),
    .all_off_o (all_off_o),
    .ovf_o     (ovf_o),
    .unf_o     (unf_o)
);

// File: tb/sim_simt_mask_stack.sv
module sim_simt_mask_stack;
    localparam int CLK_PERIOD = 10;
    localparam int LN = 32;
    localparam int DP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0, flip_i = 1'b0, pop_i = 1'b0;
    logic [LN-1:0] pred_i = '0;
    logic [LN-1:0] mask_o;
    logic          all_off_o, ovf_o, unf_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [LN-1:0] m_mask;
    logic [LN-1:0] m_stk [DP];
    int            m_sp;

    simt_mask_stack #(.LANES(LN), .DEPTH(DP)) u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .flip_i(flip_i), .pop_i(pop_i),
        .pred_i(pred_i), .mask_o(mask_o), .all_off_o(all_off_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [LN-1:0] act, input logic [LN-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle of strobes, update the model, sample outputs after the edge
    task automatic step(input logic p, input logic f, input logic o, input logic [LN-1:0] pr, input string req);
        logic eo, eu;
        eo = 1'b0; eu = 1'b0;
        @(negedge clk);
        push_i = p; flip_i = f; pop_i = o; pred_i = pr;
        if (p) begin
            if (m_sp == DP) eo = 1'b1;
            else begin m_stk[m_sp] = m_mask; m_sp++; m_mask = m_mask & pr; end
        end else if (f) begin
            if (m_sp == 0) eu = 1'b1;
            else m_mask = m_stk[m_sp-1] & ~m_mask;
        end else if (o) begin
            if (m_sp == 0) eu = 1'b1;
            else begin m_sp--; m_mask = m_stk[m_sp]; end
        end
        @(negedge clk);
        push_i = 1'b0; flip_i = 1'b0; pop_i = 1'b0;
        check(mask_o == m_mask, {req, " mask"}, mask_o, m_mask);
        check(all_off_o == (m_mask == '0), {req, " all_off R7"}, LN'(all_off_o), LN'(m_mask == '0));
        check(ovf_o == eo, {req, " ovf"}, LN'(ovf_o), LN'(eo));
        check(unf_o == eu, {req, " unf"}, LN'(unf_o), LN'(eu));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_mask = '1; m_sp = 0;
        check(mask_o == '1, "R1 reset mask", mask_o, '1);
        check({all_off_o, ovf_o, unf_o} == 3'b000, "R1 reset flags", LN'({all_off_o, ovf_o, unf_o}), '0);
        step(0, 0, 1, '0, "R1 pop after reset");
    endtask

    task automatic t_if_else();
        step(1, 0, 0, 32'h0000_FFFF, "R2 push");
        check(mask_o == 32'h0000_FFFF, "R2 literal", mask_o, 32'h0000_FFFF);
        step(0, 1, 0, '0, "R4 flip");
        check(mask_o == 32'hFFFF_0000, "R4 literal", mask_o, 32'hFFFF_0000);
        step(0, 0, 1, '0, "R5 pop");
        check(mask_o == '1, "R5 literal", mask_o, '1);
    endtask

    task automatic t_nested();
        step(1, 0, 0, 32'hF0F0_F0F0, "R10 level1");
        step(1, 0, 0, 32'hFF00_FF00, "R10 level2");
        step(1, 0, 0, 32'h0F0F_0F0F, "R10 level3 R7");
        check(all_off_o == 1'b1, "R7 literal zero mask", LN'(all_off_o), 1);
        step(0, 1, 0, '0, "R10 flip level3");
        step(0, 0, 1, '0, "R10 pop level3");
        check(mask_o == 32'hF000_F000, "R10 literal", mask_o, 32'hF000_F000);
        step(0, 0, 1, '0, "R10 pop level2");
        step(0, 0, 1, '0, "R10 pop level1");
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DP; i++) step(1, 0, 0, ~(32'h1 << i), "R2 fill");
        step(1, 0, 0, 32'h0, "R3 overflow");
        step(0, 0, 0, '0, "R9 idle after ovf");
        for (int i = 0; i < DP; i++) step(0, 0, 1, '0, "R5 drain");
    endtask

    task automatic t_underflow();
        step(0, 1, 0, 32'h1234_5678, "R6 flip empty");
        step(0, 0, 1, '0, "R6 pop empty");
    endtask

    task automatic t_priority();
        step(1, 1, 1, 32'h0000_00FF, "R8 push wins");
        step(0, 1, 1, '0, "R8 flip over pop");
        check(mask_o == 32'hFFFF_FF00, "R8 literal", mask_o, 32'hFFFF_FF00);
        step(0, 0, 1, '0, "R5 pop back");
    endtask

    task automatic t_idle();
        step(1, 0, 0, 32'hAAAA_5555, "R2 push before idle");
        step(0, 0, 0, 32'hFFFF_FFFF, "R9 idle");
        step(0, 0, 0, 32'h0, "R9 idle2");
        step(0, 0, 1, '0, "R5 pop after idle");
    endtask

    initial begin
        t_reset();
        t_if_else();
        t_nested();
        t_overflow();
        t_underflow();
        t_priority();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule